// File: doc/BRIEF.md
# Accumulator Execute Unit with Byte Register File

This block is the arithmetic stage of a small 8-bit controller. It holds a working accumulator and a register file of 128 bytes. Each cycle it may accept one already decoded operation, which is either an add or a bitwise AND. The second operand is an immediate byte or the byte stored at a register address. For operations that read a register, a destination bit chooses where the result goes: back into the accumulator, or into the register it was read from. Every operation finishes in a single clock.

Three status flags travel with the results. Carry records a carry out of the byte. Half-carry records a carry out of the low nibble. Zero marks a result of zero. Add operations update all three flags. AND operations update only Zero. A second, independent read port lets the surrounding logic, or a testbench, look at any register without disturbing execution.

Top module: `acc_alu_unit`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the accumulator, all three flags and every register-file entry to zero.
- R2: On a cycle with op_valid low, the accumulator, the flags and the register file keep their values, whatever the other inputs are.
- R3: op_code 0 (add immediate) loads the accumulator with (accumulator + op_lit) modulo 256, and sets flag_c exactly when that sum exceeds 255.
- R4: For both add operations, flag_dc is set exactly when the sum of the low four bits of the two operands exceeds 15, and is cleared otherwise.
- R5: For every operation, flag_z is set when the 8-bit result is zero and cleared when it is not, whichever destination receives the result.
- R6: op_code 1 (add register) adds the register at op_addr to the accumulator and updates flag_c as in R3. With op_dest 0 the sum goes to the accumulator and the register is unchanged. With op_dest 1 the sum goes to that register and the accumulator is unchanged.
- R7: op_code 2 (AND immediate) loads the accumulator with accumulator AND op_lit, and leaves flag_c and flag_dc unchanged.
- R8: op_code 3 (AND register) computes accumulator AND the register at op_addr. The destination is chosen by op_dest as in R6, and flag_c and flag_dc are left unchanged.
- R9: The result and flags of an operation accepted at one clock edge are visible on the outputs immediately after that edge, and peek_data shows the register at peek_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Execute the presented operation at this edge |
| op_code | input | 2 | 0 add imm, 1 add reg, 2 AND imm, 3 AND reg |
| op_lit | input | 8 | Immediate operand |
| op_addr | input | 7 | Register-file address for register forms |
| op_dest | input | 1 | Register forms: 0 to accumulator, 1 to register |
| peek_addr | input | 7 | Observation read address |
| peek_data | output | 8 | Register-file contents at peek_addr |
| acc_out | output | 8 | Accumulator |
| flag_c | output | 1 | Carry flag |
| flag_dc | output | 1 | Low-nibble carry flag |
| flag_z | output | 1 | Zero flag |

## Verification
If the accumulator or a flag is wrong, it shows on acc_out or the flag pins one edge after the operation that caused it. Each later operation carries the error forward, because the accumulator is also an operand. A wrong write to the register file can stay hidden until that address is read. The bench therefore points peek_addr at the addressed register on every operation and compares it in the same cycle. A misrouted destination then shows as a mismatch in either the accumulator or the peeked byte straight away. A long random phase drives both add and AND on all destinations, so a wrong carry or half-carry surfaces within a few operations.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [1:0] {
      OPC_ADD_IMM = 2'b00,
      OPC_ADD_REG = 2'b01,
      OPC_AND_IMM = 2'b10,
      OPC_AND_REG = 2'b11
   } opc_e;

   // bit 0 of the code selects a register operand, bit 1 selects AND
   localparam int OPC_REG_BIT = 0;
   localparam int OPC_AND_BIT = 1;

endpackage

// File: rtl/acc_alu_rf.sv
module acc_alu_rf #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 7,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   output logic [DATA_W-1:0] rd_data_b
);

   logic [DATA_W-1:0] cells [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (rst) begin
            cells[i] <= '0;
         end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
            cells[i] <= wr_data;
         end
      end
   end

   assign rd_data_a = cells[rd_addr_a];
   assign rd_data_b = cells[rd_addr_b];

endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec #(
   parameter int DATA_W     = 8,
   parameter int NIB_W      = 4,
   parameter bit SPLIT_ADD  = 1'b1,
   localparam int HI_W      = DATA_W - NIB_W
) (
   input  logic              is_and,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic [DATA_W-1:0] result,
   output logic              carry,
   output logic              nib_carry,
   output logic              zero
);

   logic [DATA_W-1:0] sum;
   logic              sum_c;
   logic [NIB_W:0]    lo_sum;

   assign lo_sum = {1'b0, opnd_a[NIB_W-1:0]} + {1'b0, opnd_b[NIB_W-1:0]};

   if (SPLIT_ADD) begin : g_split
      // chained nibble adder: low half feeds its carry into the high half
      logic [HI_W:0] hi_sum;
      assign hi_sum = {1'b0, opnd_a[DATA_W-1:NIB_W]} + {1'b0, opnd_b[DATA_W-1:NIB_W]}
                      + {{HI_W{1'b0}}, lo_sum[NIB_W]};
      assign sum   = {hi_sum[HI_W-1:0], lo_sum[NIB_W-1:0]};
      assign sum_c = hi_sum[HI_W];
   end else begin : g_flat
      logic [DATA_W:0] full;
      assign full  = {1'b0, opnd_a} + {1'b0, opnd_b};
      assign sum   = full[DATA_W-1:0];
      assign sum_c = full[DATA_W];
   end

   always_comb begin
      if (is_and) begin
         result    = opnd_a & opnd_b;
         carry     = 1'b0;
         nib_carry = 1'b0;
      end else begin
         result    = sum;
         carry     = sum_c;
         nib_carry = lo_sum[NIB_W];
      end
      zero = (result == '0);
   end

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 7,
   parameter int NIB_W     = 4,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_valid,
   input  logic [1:0]        op_code,
   input  logic [DATA_W-1:0] op_lit,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic              op_dest,
   input  logic [ADDR_W-1:0] peek_addr,
   output logic [DATA_W-1:0] peek_data,
   output logic [DATA_W-1:0] acc_out,
   output logic              flag_c,
   output logic              flag_dc,
   output logic              flag_z
);
   import acc_alu_pkg::*;

   if (NIB_W < 1 || NIB_W >= DATA_W) begin : g_bad_nib
      $error("acc_alu_unit: NIB_W must lie between 1 and DATA_W-1");
   end
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("acc_alu_unit: ADDR_W must lie between 1 and 10");
   end

   opc_e              opc;
   logic              use_reg;
   logic              is_and;
   logic              to_reg;
   logic [DATA_W-1:0] reg_val;
   logic [DATA_W-1:0] opnd_b;
   logic [DATA_W-1:0] res;
   logic              res_c;
   logic              res_dc;
   logic              res_z;
   logic [DATA_W-1:0] w_q;
   logic              c_q, dc_q, z_q;

   assign opc     = opc_e'(op_code);
   assign use_reg = opc[OPC_REG_BIT];
   assign is_and  = opc[OPC_AND_BIT];
   assign to_reg  = use_reg & op_dest;
   assign opnd_b  = use_reg ? reg_val : op_lit;

   acc_alu_rf #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_rf (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (op_valid & to_reg),
      .wr_addr   (op_addr),
      .wr_data   (res),
      .rd_addr_a (op_addr),
      .rd_data_a (reg_val),
      .rd_addr_b (peek_addr),
      .rd_data_b (peek_data)
   );

   acc_alu_exec #(
      .DATA_W    (DATA_W),
      .NIB_W     (NIB_W),
      .SPLIT_ADD (SPLIT_ADD)
   ) u_exec (
      .is_and    (is_and),
      .opnd_a    (w_q),
      .opnd_b    (opnd_b),
      .result    (res),
      .carry     (res_c),
      .nib_carry (res_dc),
      .zero      (res_z)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         w_q  <= '0;
         c_q  <= 1'b0;
         dc_q <= 1'b0;
         z_q  <= 1'b0;
      end else if (op_valid) begin
         if (!to_reg) begin
            w_q <= res;
         end
         z_q <= res_z;
         if (!is_and) begin
            c_q  <= res_c;
            dc_q <= res_dc;
         end
      end
   end

   assign acc_out = w_q;
   assign flag_c  = c_q;
   assign flag_dc = dc_q;
   assign flag_z  = z_q;

endmodule

// File: rtl/acc_alu_unit_chk.sv
module acc_alu_unit_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              op_valid,
   input logic [1:0]        op_code,
   input logic [DATA_W-1:0] op_lit,
   input logic              op_dest,
   input logic [DATA_W-1:0] acc_out,
   input logic              flag_c,
   input logic              flag_dc,
   input logic              flag_z
);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !op_valid |=> ($stable(acc_out) && $stable(flag_c) && $stable(flag_dc) && $stable(flag_z)));

   // R3
   add_imm_sum_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_code == 2'd0) |=> (acc_out == DATA_W'($past(acc_out) + $past(op_lit))));

   // R5
   zero_tracks_acc_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !(op_code[0] && op_dest)) |=> (flag_z == (acc_out == '0)));

   // R6
   reg_dest_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_code[0] && op_dest) |=> $stable(acc_out));

   // R7
   and_keeps_carries_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_code[1]) |=> ($stable(flag_c) && $stable(flag_dc)));

   // R7
   and_imm_result_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_code == 2'd2) |=> (acc_out == ($past(acc_out) & $past(op_lit))));

endmodule

bind acc_alu_unit acc_alu_unit_chk #(
   .DATA_W (DATA_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .op_valid (op_valid),
   .op_code  (op_code),
   .op_lit   (op_lit),
   .op_dest  (op_dest),
   .acc_out  (acc_out),
   .flag_c   (flag_c),
   .flag_dc  (flag_dc),
   .flag_z   (flag_z)
);

// File: tb/acc_alu_unit_tb.sv
module acc_alu_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 128;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       op_valid = 1'b0;
   logic [1:0] op_code = 2'd0;
   logic [7:0] op_lit = 8'd0;
   logic [6:0] op_addr = 7'd0;
   logic       op_dest = 1'b0;
   logic [6:0] peek_addr = 7'd0;
   logic [7:0] peek_data;
   logic [7:0] acc_out;
   logic       flag_c, flag_dc, flag_z;

   int total = 0;
   int bad   = 0;

   // bench model
   logic [7:0] m_w;
   logic       m_c, m_dc, m_z;
   logic [7:0] m_mem [DEPTH];

   // scoreboard queues
   logic [7:0] q_acc  [$];
   logic [2:0] q_flg  [$];
   logic [7:0] q_pk   [$];
   string      q_tag  [$];
   logic       q_add  [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_alu_unit u_dut (
      .clk       (clk),
      .rst       (rst),
      .op_valid  (op_valid),
      .op_code   (op_code),
      .op_lit    (op_lit),
      .op_addr   (op_addr),
      .op_dest   (op_dest),
      .peek_addr (peek_addr),
      .peek_data (peek_data),
      .acc_out   (acc_out),
      .flag_c    (flag_c),
      .flag_dc   (flag_dc),
      .flag_z    (flag_z)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_w = '0; m_c = 1'b0; m_dc = 1'b0; m_z = 1'b0;
      for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
   endtask

   // driver: presents one cycle of stimulus and queues its expected outcome
   task automatic drive(input logic v, input logic [1:0] opc, input logic [7:0] lit,
                        input logic [6:0] adr, input logic d);
      logic [7:0] opnd, r;
      logic [8:0] s9;
      logic [4:0] n5;
      string      tag;
      @(negedge clk);
      op_valid = v; op_code = opc; op_lit = lit; op_addr = adr; op_dest = d;
      peek_addr = adr;
      if (!v) begin
         tag = "R2";
      end else begin
         opnd = opc[0] ? m_mem[adr] : lit;
         if (opc[1]) begin
            r = m_w & opnd;
         end else begin
            s9   = {1'b0, m_w} + {1'b0, opnd};
            n5   = {1'b0, m_w[3:0]} + {1'b0, opnd[3:0]};
            r    = s9[7:0];
            m_c  = s9[8];
            m_dc = n5[4];
         end
         m_z = (r == 8'd0);
         if (opc[0] && d) m_mem[adr] = r;
         else             m_w = r;
         case (opc)
            2'd0:    tag = "R3 R9";
            2'd1:    tag = "R6";
            2'd2:    tag = "R7";
            default: tag = "R8";
         endcase
      end
      q_acc.push_back(m_w);
      q_flg.push_back({m_c, m_dc, m_z});
      q_pk.push_back(m_mem[adr]);
      q_tag.push_back(tag);
      q_add.push_back(v && !opc[1]);
   endtask

   // monitor: compares one queued item shortly after each edge
   always begin
      @(posedge clk);
      #1;
      if (q_acc.size() > 0) begin
         logic [7:0] e_acc, e_pk;
         logic [2:0] e_f;
         string      t;
         logic       was_add;
         e_acc = q_acc.pop_front();
         e_f   = q_flg.pop_front();
         e_pk  = q_pk.pop_front();
         t     = q_tag.pop_front();
         was_add = q_add.pop_front();
         chk({t, " acc"}, acc_out, e_acc);
         chk({t, " carry"}, {7'd0, flag_c}, {7'd0, e_f[2]});
         chk(was_add ? "R4 half-carry" : {t, " half-carry"}, {7'd0, flag_dc}, {7'd0, e_f[1]});
         chk("R5 zero", {7'd0, flag_z}, {7'd0, e_f[0]});
         chk({t, " register"}, peek_data, e_pk);
      end
   end

   task automatic check_reset_state();
      int wrong = 0;
      chk("R1 acc", acc_out, 8'd0);
      chk("R1 flags", {5'd0, flag_c, flag_dc, flag_z}, 8'd0);
      for (int i = 0; i < DEPTH; i++) begin
         peek_addr = 7'(i);
         #0.1;
         if (peek_data !== 8'd0) wrong++;
      end
      chk("R1 register file nonzero entries", 8'(wrong), 8'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check_reset_state();

      // directed sequence
      drive(1, 2'd0, 8'h0F, 7'd5, 0);   // W=0F
      drive(1, 2'd0, 8'h01, 7'd5, 0);   // W=10, half-carry
      drive(1, 2'd1, 8'h00, 7'd5, 1);   // reg5=10, W kept
      drive(1, 2'd0, 8'hF0, 7'd5, 0);   // W=00, C=1, Z=1
      drive(1, 2'd2, 8'hFF, 7'd5, 0);   // W=00, C kept
      drive(0, 2'd1, 8'hAA, 7'd5, 1);   // idle with live-looking inputs
      drive(0, 2'd0, 8'h55, 7'd9, 0);
      drive(1, 2'd0, 8'h88, 7'd9, 0);   // W=88
      drive(1, 2'd1, 8'h00, 7'd5, 0);   // W=98
      drive(1, 2'd3, 8'h00, 7'd5, 1);   // reg5=10
      drive(1, 2'd3, 8'h00, 7'd5, 0);   // W=10
      drive(1, 2'd2, 8'h0F, 7'd5, 0);   // W=00, Z=1
      drive(1, 2'd0, 8'h08, 7'd0, 0);
      drive(1, 2'd0, 8'h08, 7'd0, 0);   // low nibble 8+8 carries
      drive(1, 2'd1, 8'h00, 7'd127, 1); // top address

      // random phase
      for (int k = 0; k < 600; k++) begin
         drive(($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)),
               8'($urandom_range(0, 255)), 7'($urandom_range(0, 15)),
               1'($urandom_range(0, 1)));
      end
      drive(0, 2'd0, 8'h00, 7'd0, 0);
      while (q_acc.size() > 0) @(negedge clk);

      // reset again after registers have been written
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      model_reset();
      check_reset_state();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule